// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a fully associative translation cache of configurable depth. Each slot stores a valid flag, a virtual page number tag, a physical page number, an address space number, a global flag, and an opaque bundle of permission bits. The permission bits hold per-mode read and write enables plus fault-on-read and fault-on-write flags. A lookup presents a virtual page number and the current address space number. The matching physical page number and permission bits return in the same cycle.

Translations are loaded at a round-robin victim slot. Three invalidation commands are provided. One empties the whole buffer. One removes every entry that is not global, for use on a context switch. One removes the translation of one page within one address space. Page table walks, permission checks and physical address assembly are done by the surrounding logic. The usual configurations are 48 slots for instruction fetch and 64 slots for data.

Top module: `as_tlb`

## Requirements
- R1: A lookup hits only on a valid slot whose tag equals `lk_vpn` and whose global flag is set or whose stored address space number equals `lk_asn`.
- R2: An insert writes all fields of the slot named by the victim pointer at the next clock edge, replacing any valid translation held there.
- R3: The victim pointer is zero after reset and advances by one, wrapping from DEPTH-1 to 0, only on a cycle in which an insert is performed; after DEPTH inserts the next insert replaces the first.
- R4: `flush_all` invalidates every slot at the next edge.
- R5: `flush_proc` invalidates every non-global slot at the next edge; global slots keep hitting.
- R6: `flush_addr` invalidates every slot whose tag equals `fl_vpn` and whose global flag is set or whose address space number equals `fl_asn`; other slots are unaffected.
- R7: When several commands are raised in one cycle, only the highest one acts, in the order flush_all, flush_proc, flush_addr, insert; a suppressed insert writes nothing and does not move the pointer.
- R8: When several slots hit, the outputs come from the lowest-numbered slot.
- R9: `lk_hit`, `lk_ppn` and `lk_perm` are combinational in `lk_vpn` and `lk_asn`; on a miss `lk_ppn` and `lk_perm` are zero.
- R10: After reset every slot is invalid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Lookup address space number |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Physical page number of the hit |
| lk_perm | output | PERM_W | Permission bits of the hit |
| ins_en | input | 1 | Insert request |
| ins_vpn | input | VPN_W | Tag to insert |
| ins_ppn | input | PPN_W | Physical page to insert |
| ins_asn | input | ASN_W | Address space of the insert |
| ins_global | input | 1 | Global flag of the insert |
| ins_perm | input | PERM_W | Permission bits of the insert |
| flush_all | input | 1 | Invalidate all slots |
| flush_proc | input | 1 | Invalidate non-global slots |
| flush_addr | input | 1 | Invalidate one page in one address space |
| fl_vpn | input | VPN_W | Page for flush_addr |
| fl_asn | input | ASN_W | Address space for flush_addr |

## Verification
A victim pointer that drifts or skips a slot appears only when the buffer wraps. A translation then survives one insert too long, or disappears one insert too early. The bench therefore fills the buffer past DEPTH and probes the first slots. A stuck or wrongly qualified valid flag shows on the very next lookup after a flush, as a hit that should be a miss or the reverse. A wrong address space or global check shows as soon as the same page is looked up under a foreign address space number. Random traffic over a small pool of page numbers makes duplicates and partial flushes frequent, so the lowest-slot rule and the flush qualifiers are compared against a bench model on every cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [2:0] {
    OP_IDLE, OP_CLR_ALL, OP_CLR_PROC, OP_CLR_PAGE, OP_LOAD
  } tlb_op_e;

  function automatic tlb_op_e pick_op(input logic fa, input logic fp,
                                      input logic fadr, input logic ins);
    if (fa)        return OP_CLR_ALL;
    else if (fp)   return OP_CLR_PROC;
    else if (fadr) return OP_CLR_PAGE;
    else if (ins)  return OP_LOAD;
    else           return OP_IDLE;
  endfunction
endpackage

// File: rtl/tlb_victim_ptr.sv
module tlb_victim_ptr #(
  parameter int DEPTH = 48,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    idx_d = idx;
    if (adv) idx_d = (idx == IDX_W'(DEPTH-1)) ? '0 : idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (adv) idx <= idx_d;
  end
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int DEPTH  = 48,
  parameter int VPN_W  = 28,
  parameter int PPN_W  = 24,
  parameter int ASN_W  = 8,
  parameter int PERM_W = 10,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tlb_op_e           op,
  input  logic [IDX_W-1:0]  victim,
  input  logic [VPN_W-1:0]  ins_vpn,
  input  logic [PPN_W-1:0]  ins_ppn,
  input  logic [ASN_W-1:0]  ins_asn,
  input  logic              ins_global,
  input  logic [PERM_W-1:0] ins_perm,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [ASN_W-1:0]  fl_asn,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASN_W-1:0]  lk_asn,
  output logic [DEPTH-1:0]  hit_vec,
  output logic [DEPTH-1:0]  valid_vec,
  output logic [DEPTH-1:0]  glb_vec,
  output logic [PPN_W-1:0]  ppn_q  [DEPTH],
  output logic [PERM_W-1:0] perm_q [DEPTH]
);
  logic [VPN_W-1:0] vpn_q [DEPTH];
  logic [ASN_W-1:0] asn_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wr_en, kill, valid_d;

    always_comb begin
      wr_en = (op == OP_LOAD) && (victim == IDX_W'(g));
      unique case (op)
        OP_CLR_ALL:  kill = 1'b1;
        OP_CLR_PROC: kill = !glb_vec[g];
        OP_CLR_PAGE: kill = (vpn_q[g] == fl_vpn) &&
                            (glb_vec[g] || asn_q[g] == fl_asn);
        default:     kill = 1'b0;
      endcase
      valid_d = wr_en ? 1'b1 : (kill ? 1'b0 : valid_vec[g]);
      hit_vec[g] = valid_vec[g] && (vpn_q[g] == lk_vpn) &&
                   (glb_vec[g] || asn_q[g] == lk_asn);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_vec[g] <= 1'b0;
      else        valid_vec[g] <= valid_d;
    end

    always_ff @(posedge clk) begin
      if (wr_en) begin
        vpn_q[g]   <= ins_vpn;
        ppn_q[g]   <= ins_ppn;
        asn_q[g]   <= ins_asn;
        glb_vec[g] <= ins_global;
        perm_q[g]  <= ins_perm;
      end
    end
  end
endmodule

// File: rtl/tlb_match_sel.sv
module tlb_match_sel #(
  parameter int DEPTH  = 48,
  parameter int PPN_W  = 24,
  parameter int PERM_W = 10
) (
  input  logic [DEPTH-1:0]  hit_vec,
  input  logic [PPN_W-1:0]  ppn_q  [DEPTH],
  input  logic [PERM_W-1:0] perm_q [DEPTH],
  output logic              hit,
  output logic [PPN_W-1:0]  ppn,
  output logic [PERM_W-1:0] perm
);
  always_comb begin
    hit  = 1'b0;
    ppn  = '0;
    perm = '0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit  = 1'b1;
        ppn  = ppn_q[i];
        perm = perm_q[i];
      end
    end
  end
endmodule

// File: rtl/as_tlb.sv
module as_tlb
  import tlb_pkg::*;
#(
  parameter int DEPTH  = 48,
  parameter int VPN_W  = 28,
  parameter int PPN_W  = 24,
  parameter int ASN_W  = 8,
  parameter int PERM_W = 10,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASN_W-1:0]  lk_asn,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              ins_en,
  input  logic [VPN_W-1:0]  ins_vpn,
  input  logic [PPN_W-1:0]  ins_ppn,
  input  logic [ASN_W-1:0]  ins_asn,
  input  logic              ins_global,
  input  logic [PERM_W-1:0] ins_perm,
  input  logic              flush_all,
  input  logic              flush_proc,
  input  logic              flush_addr,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [ASN_W-1:0]  fl_asn
);
  tlb_op_e          op;
  logic [IDX_W-1:0] victim_idx;
  logic [DEPTH-1:0] hit_vec, valid_vec, glb_vec;
  logic [PPN_W-1:0]  ppn_q  [DEPTH];
  logic [PERM_W-1:0] perm_q [DEPTH];

  assign op = pick_op(flush_all, flush_proc, flush_addr, ins_en);

  tlb_victim_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(op == OP_LOAD), .idx(victim_idx)
  );

  tlb_entry_store #(
    .DEPTH(DEPTH), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W), .PERM_W(PERM_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .op(op), .victim(victim_idx),
    .ins_vpn(ins_vpn), .ins_ppn(ins_ppn), .ins_asn(ins_asn),
    .ins_global(ins_global), .ins_perm(ins_perm),
    .fl_vpn(fl_vpn), .fl_asn(fl_asn), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
    .hit_vec(hit_vec), .valid_vec(valid_vec), .glb_vec(glb_vec),
    .ppn_q(ppn_q), .perm_q(perm_q)
  );

  tlb_match_sel #(.DEPTH(DEPTH), .PPN_W(PPN_W), .PERM_W(PERM_W)) u_sel (
    .hit_vec(hit_vec), .ppn_q(ppn_q), .perm_q(perm_q),
    .hit(lk_hit), .ppn(lk_ppn), .perm(lk_perm)
  );
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int DEPTH = 48,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_en,
  input logic             flush_all,
  input logic             flush_proc,
  input logic             flush_addr,
  input logic             lk_hit,
  input logic [IDX_W-1:0] victim_idx,
  input logic [DEPTH-1:0] valid_vec,
  input logic [DEPTH-1:0] glb_vec
);
  logic any_flush, ins_go;
  assign any_flush = flush_all | flush_proc | flush_addr;
  assign ins_go    = ins_en & ~any_flush;

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_go |=> victim_idx == (($past(victim_idx) == IDX_W'(DEPTH-1)) ? '0
                              : $past(victim_idx) + 1'b1));
  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_go |=> $stable(victim_idx));
  // R2
  ins_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_go |=> valid_vec[$past(victim_idx)]);
  // R4
  flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> valid_vec == '0);
  // R5
  flush_proc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_proc && !flush_all) |=>
      ((valid_vec & ~glb_vec) == '0) &&
      ((valid_vec & glb_vec) == $past(valid_vec & glb_vec)));
  // R10
  empty_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_vec == '0) |-> !lk_hit);
endmodule

bind as_tlb tlb_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .flush_all(flush_all),
  .flush_proc(flush_proc), .flush_addr(flush_addr), .lk_hit(lk_hit),
  .victim_idx(victim_idx), .valid_vec(valid_vec), .glb_vec(glb_vec)
);

// File: tb/as_tlb_bench.sv
module as_tlb_bench;
  localparam int DEPTH = 48, VPN_W = 28, PPN_W = 24, ASN_W = 8, PERM_W = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [VPN_W-1:0] lk_vpn, ins_vpn, fl_vpn;
  logic [ASN_W-1:0] lk_asn, ins_asn, fl_asn;
  logic [PPN_W-1:0] ins_ppn, lk_ppn;
  logic [PERM_W-1:0] ins_perm, lk_perm;
  logic lk_hit, ins_en, ins_global, flush_all, flush_proc, flush_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  bit               m_v [DEPTH];
  bit               m_g [DEPTH];
  logic [VPN_W-1:0] m_vpn [DEPTH];
  logic [ASN_W-1:0] m_asn [DEPTH];
  logic [PPN_W-1:0] m_ppn [DEPTH];
  logic [PERM_W-1:0] m_perm [DEPTH];
  int m_ptr;

  always #4 clk = ~clk;

  as_tlb #(.DEPTH(DEPTH), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W),
           .PERM_W(PERM_W)) u_as_tlb (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_perm(lk_perm),
    .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn), .ins_asn(ins_asn),
    .ins_global(ins_global), .ins_perm(ins_perm), .flush_all(flush_all),
    .flush_proc(flush_proc), .flush_addr(flush_addr), .fl_vpn(fl_vpn),
    .fl_asn(fl_asn)
  );

  function automatic bit slot_hit(int i, logic [VPN_W-1:0] v, logic [ASN_W-1:0] a);
    return m_v[i] && m_vpn[i] == v && (m_g[i] || m_asn[i] == a);
  endfunction

  task automatic model_edge();
    if (flush_all) begin
      for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
    end else if (flush_proc) begin
      for (int i = 0; i < DEPTH; i++) if (!m_g[i]) m_v[i] = 0;
    end else if (flush_addr) begin
      for (int i = 0; i < DEPTH; i++) if (slot_hit(i, fl_vpn, fl_asn)) m_v[i] = 0;
    end else if (ins_en) begin
      m_v[m_ptr] = 1; m_g[m_ptr] = ins_global; m_vpn[m_ptr] = ins_vpn;
      m_asn[m_ptr] = ins_asn; m_ppn[m_ptr] = ins_ppn; m_perm[m_ptr] = ins_perm;
      m_ptr = (m_ptr + 1) % DEPTH;
    end
  endtask

  task automatic idle_ops();
    ins_en = 0; flush_all = 0; flush_proc = 0; flush_addr = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    #2;
    idle_ops();
  endtask

  task automatic probe(input logic [VPN_W-1:0] v, input logic [ASN_W-1:0] a,
                       input string req);
    bit eh = 0;
    logic [PPN_W-1:0] ep = '0;
    logic [PERM_W-1:0] er = '0;
    lk_vpn = v; lk_asn = a;
    #1;
    for (int i = DEPTH-1; i >= 0; i--)
      if (slot_hit(i, v, a)) begin eh = 1; ep = m_ppn[i]; er = m_perm[i]; end
    checks++;
    if (lk_hit !== eh || lk_ppn !== ep || lk_perm !== er) begin
      errors++;
      $display("FAIL %s: vpn=%h asn=%h got hit=%b ppn=%h perm=%h exp hit=%b ppn=%h perm=%h",
               req, v, a, lk_hit, lk_ppn, lk_perm, eh, ep, er);
    end
  endtask

  task automatic load(input logic [VPN_W-1:0] v, input logic [ASN_W-1:0] a,
                      input bit g, input logic [PPN_W-1:0] p);
    ins_en = 1; ins_vpn = v; ins_asn = a; ins_global = g; ins_ppn = p;
    ins_perm = PERM_W'(p ^ 10'h2a5);
    tick();
  endtask

  initial begin
    #150000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle_ops();
    ins_vpn = '0; ins_asn = '0; ins_ppn = '0; ins_perm = '0; ins_global = 0;
    fl_vpn = '0; fl_asn = '0; lk_vpn = '0; lk_asn = '0;
    for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
    m_ptr = 0;
    rst_n = 0;
    #20 rst_n = 1;
    @(negedge clk);

    // R10: empty after reset
    probe('0, '0, "R10");
    probe(28'h123, 8'h5, "R10");

    // R1: global matches any ASN, non-global needs ASN
    load(28'h10, 8'h3, 1, 24'hA0);
    load(28'h11, 8'h3, 0, 24'hA1);
    probe(28'h10, 8'h9, "R1");
    probe(28'h11, 8'h9, "R1");
    probe(28'h11, 8'h3, "R9");

    // R8: duplicate tag, lowest slot wins
    load(28'h10, 8'h3, 1, 24'hB0);
    probe(28'h10, 8'h3, "R8");

    // R3/R2: fill past depth; slot 0 replaced by the DEPTH+1-th insert
    for (int i = 3; i < DEPTH; i++) load(28'h100 + i, 8'h1, 0, 24'h1000 + i);
    probe(28'h10, 8'h3, "R3");
    load(28'h200, 8'h1, 0, 24'hC0);
    probe(28'h10, 8'h3, "R2");
    probe(28'h200, 8'h1, "R2");
    probe(28'h11, 8'h3, "R3");

    // R5: flush non-global
    load(28'h300, 8'h7, 1, 24'hD0);
    flush_proc = 1; tick();
    probe(28'h300, 8'h2, "R5");
    probe(28'h200, 8'h1, "R5");

    // R6: flush one page
    load(28'h400, 8'h4, 0, 24'hE0);
    load(28'h401, 8'h4, 0, 24'hE1);
    fl_vpn = 28'h400; fl_asn = 8'h5; flush_addr = 1; tick();
    probe(28'h400, 8'h4, "R6");
    fl_vpn = 28'h400; fl_asn = 8'h4; flush_addr = 1; tick();
    probe(28'h400, 8'h4, "R6");
    probe(28'h401, 8'h4, "R6");

    // R7: flush_addr beats insert
    ins_en = 1; ins_vpn = 28'h500; ins_asn = 8'h1; ins_global = 0;
    ins_ppn = 24'hF0; ins_perm = '1;
    fl_vpn = 28'h999; flush_addr = 1; tick();
    probe(28'h500, 8'h1, "R7");

    // R4: flush all, with insert suppressed
    ins_en = 1; ins_vpn = 28'h501; flush_all = 1; tick();
    probe(28'h300, 8'h0, "R4");
    probe(28'h501, 8'h1, "R7");
    probe(28'h401, 8'h4, "R4");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int sel = $urandom_range(0, 99);
      ins_vpn = VPN_W'($urandom_range(0, 15)); ins_asn = ASN_W'($urandom_range(0, 3));
      ins_global = ($urandom_range(0, 3) == 0); ins_ppn = PPN_W'($urandom);
      ins_perm = PERM_W'($urandom);
      fl_vpn = VPN_W'($urandom_range(0, 15)); fl_asn = ASN_W'($urandom_range(0, 3));
      ins_en = (sel < 70) || (sel >= 97);
      flush_addr = (sel >= 70 && sel < 90) || sel == 99;
      flush_proc = (sel >= 90 && sel < 95) || sel == 98;
      flush_all = (sel >= 95 && sel < 97) || sel == 99;
      tick();
      probe(VPN_W'($urandom_range(0, 15)), ASN_W'($urandom_range(0, 3)), "R1");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule